// File: doc/BRIEF.md
# Iterative Signed Integer Multiplier

This unit forms the product of two operands over many clock cycles for the execute stage of a 64-bit processor. Each operand arrives 65 bits wide. The requester has already widened it: bit 64 carries the sign for a signed operation and is zero for an unsigned one. Narrow 32-bit operations are extended the same way from bit 31. Because of this, the unit always performs a signed 65 x 65 multiply, and the 130-bit product is exact.

A one-cycle start pulse loads the operands, a 2-bit result select and a 32-bit mode flag. A radix-4 recoded shift-add datapath then retires two multiplier bits per cycle. A final registered stage picks one of three results: the low 64 bits, the high 64 bits, or the high word of a 32-bit product. The result and an overflow flag appear with a one-cycle done pulse. The requester stalls its pipe until that pulse arrives and writes the result back itself. Only one multiply is in flight at a time.

Top module: `mul_iter_unit`

## Requirements
- R1: With sel_i = 2'b00 (code 2'b11 behaves the same), result_o equals bits 63..0 of the signed product of opa_i and opb_i, each read as a 65-bit two's-complement number.
- R2: With sel_i = 2'b01, result_o equals bits 127..64 of that signed product.
- R3: With sel_i = 2'b10, result_o[31:0] and result_o[63:32] both equal product bits 63..32.
- R4: done_o is high for exactly one cycle. It rises 34 rising edges after the edge that samples start_i high.
- R5: A start_i pulse is ignored while an operation is in progress, from the accepting edge until done_o rises. It changes neither the pending result nor the number of done pulses.
- R6: For sel_i = 2'b00 with mode32_i = 0, ovf_o is 1 exactly when the product lies outside the signed 64-bit range.
- R7: For sel_i = 2'b00 with mode32_i = 1, ovf_o is 1 exactly when the product lies outside the signed 32-bit range.
- R8: For sel_i = 2'b01 and 2'b10, ovf_o is 0.
- R9: result_o and ovf_o change only in the cycle where done_o is high. They hold their values between completions.
- R10: After reset, done_o, ovf_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a multiply |
| sel_i | input | 2 | Result select: 00 low 64, 01 high 64, 10 high 32 (replicated), 11 as 00 |
| mode32_i | input | 1 | Selects the 32-bit overflow range for the low select |
| opa_i | input | 65 | Pre-extended multiplicand |
| opb_i | input | 65 | Pre-extended multiplier |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Selected product bits |
| ovf_o | output | 1 | Low-half overflow flag |

## Verification
Two situations are hard to reach from the ports. The first is a second start request arriving while a multiply is still iterating. The bench reaches it by pulsing start with different operands a few cycles after an accepted start. It then checks that the completing result belongs to the first request and that no extra done pulse follows. The second is the exact edge of each overflow range. The bench reaches it with products just inside and just outside the 32-bit and 64-bit signed ranges, with the most negative operand, and with all-ones operands taken both signed and unsigned.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_HI32 = 2'b10,
    SEL_RSV  = 2'b11
  } mul_sel_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

endpackage

// File: rtl/mul_booth_recode.sv
module mul_booth_recode
  import mul_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_dig_t dig_o
);

  always_comb begin
    dig_o.one = trip_i[1] ^ trip_i[0];
    dig_o.two = (trip_i == 3'b011) || (trip_i == 3'b100);
    dig_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int OW = 65
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [OW-1:0]   opa_i,
  input  logic [OW-1:0]   opb_i,
  output logic [2*OW-1:0] acc_o
);

  localparam int PW = 2 * OW;
  localparam int MW = OW + 1;

  logic [PW-1:0] acc_q, acc_d;
  logic [PW-1:0] mcand_q, mcand_d;
  logic [MW-1:0] mplier_q, mplier_d;
  logic          prev_q, prev_d;

  booth_dig_t    dig;
  logic [PW-1:0] pp;
  logic [PW-1:0] addend;

  mul_booth_recode recode_i (
    .trip_i ({mplier_q[1:0], prev_q}),
    .dig_o  (dig)
  );

  always_comb begin
    if (dig.two)      pp = {mcand_q[PW-2:0], 1'b0};
    else if (dig.one) pp = mcand_q;
    else              pp = '0;
    addend = dig.neg ? ~pp : pp;
  end

  always_comb begin
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    prev_d   = prev_q;
    if (load_i) begin
      acc_d    = '0;
      mcand_d  = {{(PW-OW){opa_i[OW-1]}}, opa_i};
      mplier_d = {opb_i[OW-1], opb_i};
      prev_d   = 1'b0;
    end else if (step_i) begin
      acc_d    = acc_q + addend + {{(PW-1){1'b0}}, dig.neg};
      mcand_d  = {mcand_q[PW-3:0], 2'b00};
      mplier_d = {{2{mplier_q[MW-1]}}, mplier_q[MW-1:2]};
      prev_d   = mplier_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      prev_q   <= 1'b0;
    end else if (load_i || step_i) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      prev_q   <= prev_d;
    end
  end

  assign acc_o = acc_q;

  // R1: a load always clears the running sum before the first step
  a_r1_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0));

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int STEPS = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o
);

  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrl_st_e;

  ctrl_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_FIN);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_RUN;
        cnt_d = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST) st_d = ST_FIN;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: a start seen mid-run neither restarts nor stalls the step count
  a_r5_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && start_i && cnt_q != LAST) |=>
      (st_q == ST_RUN && cnt_q == $past(cnt_q) + CW'(1)));

  // R4: the finish state lasts exactly one cycle
  a_r4_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/mul_format.sv
module mul_format
  import mul_pkg::*;
#(
  parameter int DW = 64
) (
  input  mul_sel_e            sel_i,
  input  logic                mode32_i,
  input  logic [2*DW+1:0]     prod_i,
  output logic [DW-1:0]       res_o,
  output logic                ovf_o
);

  localparam int PW = 2 * DW + 2;
  localparam int HW = DW / 2;

  logic ovf_wide, ovf_narrow;

  always_comb begin
    ovf_wide   = !((&prod_i[PW-1:DW-1]) || !(|prod_i[PW-1:DW-1]));
    ovf_narrow = !((&prod_i[PW-1:HW-1]) || !(|prod_i[PW-1:HW-1]));
    res_o = prod_i[DW-1:0];
    ovf_o = 1'b0;
    unique case (sel_i)
      SEL_HI:   res_o = prod_i[2*DW-1:DW];
      SEL_HI32: res_o = {2{prod_i[DW-1:HW]}};
      default: begin
        res_o = prod_i[DW-1:0];
        ovf_o = mode32_i ? ovf_narrow : ovf_wide;
      end
    endcase
  end

endmodule

// File: rtl/mul_iter_unit.sv
module mul_iter_unit
  import mul_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    sel_i,
  input  logic          mode32_i,
  input  logic [DW:0]   opa_i,
  input  logic [DW:0]   opb_i,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          ovf_o
);

  localparam int OW    = DW + 1;
  localparam int PW    = 2 * OW;
  localparam int STEPS = (OW + 1) / 2;

  logic          load, step, fin;
  logic [PW-1:0] prod;
  logic [DW-1:0] res_d;
  logic          ovf_d;

  mul_sel_e      sel_q;
  logic          m32_q;
  logic          done_q;
  logic [DW-1:0] res_q;
  logic          ovf_q;

  mul_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin)
  );

  mul_datapath #(.OW(OW)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .acc_o  (prod)
  );

  mul_format #(.DW(DW)) fmt_i (
    .sel_i    (sel_q),
    .mode32_i (m32_q),
    .prod_i   (prod),
    .res_o    (res_d),
    .ovf_o    (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_LO;
      m32_q <= 1'b0;
    end else if (load) begin
      sel_q <= mul_sel_e'(sel_i);
      m32_q <= mode32_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: outputs hold whenever no completion is being reported
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(res_q) && $stable(ovf_q)));

  // R8: high selects never raise overflow
  a_r8_no_ovf_high: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (sel_q == SEL_HI || sel_q == SEL_HI32)) |-> !ovf_q);

  // R3: the narrow high select mirrors one word into both halves
  a_r3_halves_match: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && sel_q == SEL_HI32) |-> (res_q[DW-1:DW/2] == res_q[DW/2-1:0]));

endmodule

// File: tb/mul_iter_unit_tb_top.sv
module mul_iter_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  sel_i;
  logic        mode32_i;
  logic [64:0] opa_i;
  logic [64:0] opb_i;
  logic        done_o;
  logic [63:0] result_o;
  logic        ovf_o;

  int n_chk;
  int n_bad;

  mul_iter_unit dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sel_i    (sel_i),
    .mode32_i (mode32_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .done_o   (done_o),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [64:0] sx64(input logic [63:0] x);
    return {x[63], x};
  endfunction
  function automatic logic [64:0] zx64(input logic [63:0] x);
    return {1'b0, x};
  endfunction
  function automatic logic [64:0] sx32(input logic [31:0] x);
    return {{33{x[31]}}, x};
  endfunction
  function automatic logic [64:0] zx32(input logic [31:0] x);
    return {33'd0, x};
  endfunction

  function automatic logic [129:0] ref_prod(input logic [64:0] a, input logic [64:0] b);
    logic signed [129:0] sa, sb;
    sa = {{65{a[64]}}, a};
    sb = {{65{b[64]}}, b};
    return sa * sb;
  endfunction

  task automatic expect_ref(input logic [64:0] a, input logic [64:0] b,
                            input logic [1:0] sel, input logic m32,
                            output logic [63:0] er, output logic eo);
    logic [129:0] p;
    p = ref_prod(a, b);
    eo = 1'b0;
    if (sel == 2'b01)      er = p[127:64];
    else if (sel == 2'b10) er = {p[63:32], p[63:32]};
    else begin
      er = p[63:0];
      if (m32) eo = !((&p[129:31]) || !(|p[129:31]));
      else     eo = !((&p[129:63]) || !(|p[129:63]));
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [64:0] a, input logic [64:0] b,
                             input logic [1:0] sel, input logic m32);
    opa_i = a; opb_i = b; sel_i = sel; mode32_i = m32;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one multiply: latency, result, overflow and pulse width
  task automatic run_op(input logic [64:0] a, input logic [64:0] b,
                        input logic [1:0] sel, input logic m32, input string req);
    logic [63:0] er;
    logic        eo;
    int          lat;
    expect_ref(a, b, sel, m32, er, eo);
    @(negedge clk);
    pulse_start(a, b, sel, m32);
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R4 latency", 64'(lat - 1), 64'd34);
    chk(req, result_o, er);
    chk((sel == 2'b00) ? (m32 ? "R7 ovf" : "R6 ovf") : "R8 ovf", 64'(ovf_o), 64'(eo));
    @(negedge clk);
    chk("R4 single pulse", 64'(done_o), 64'd0);
  endtask

  task automatic test_reset;
    chk("R10 done", 64'(done_o), 64'd0);
    chk("R10 result", result_o, 64'd0);
    chk("R10 ovf", 64'(ovf_o), 64'd0);
  endtask

  task automatic test_corners;
    run_op(sx64(64'h8000_0000_0000_0000), sx64(64'h8000_0000_0000_0000), 2'b00, 1'b0, "R1 minneg sq");
    run_op(sx64(64'h8000_0000_0000_0000), sx64(64'h8000_0000_0000_0000), 2'b01, 1'b0, "R2 minneg sq");
    run_op(sx64(64'h8000_0000_0000_0000), sx64(64'hFFFF_FFFF_FFFF_FFFF), 2'b00, 1'b0, "R1 minneg x -1");
    run_op(zx64(64'hFFFF_FFFF_FFFF_FFFF), zx64(64'hFFFF_FFFF_FFFF_FFFF), 2'b01, 1'b0, "R2 unsigned ones");
    run_op(zx64(64'hFFFF_FFFF_FFFF_FFFF), zx64(64'hFFFF_FFFF_FFFF_FFFF), 2'b00, 1'b0, "R1 unsigned ones");
    run_op(sx64(64'hFFFF_FFFF_FFFF_FFFF), sx64(64'hFFFF_FFFF_FFFF_FFFF), 2'b00, 1'b0, "R1 signed ones");
    run_op(sx64(64'd0), sx64(64'h7FFF_FFFF_FFFF_FFFF), 2'b01, 1'b0, "R2 zero");
    run_op(sx64(64'h4000_0000_0000_0000), sx64(64'd2), 2'b00, 1'b0, "R6 just over");
    run_op(sx64(64'hC000_0000_0000_0000), sx64(64'd2), 2'b00, 1'b0, "R6 just inside neg");
    run_op(sx64(64'h3FFF_FFFF_FFFF_FFFF), sx64(64'd2), 2'b11, 1'b0, "R1 sel11 inside");
    run_op(sx32(32'h4000_0000), sx32(32'd2), 2'b00, 1'b1, "R7 32 over");
    run_op(sx32(32'hC000_0000), sx32(32'd2), 2'b00, 1'b1, "R7 32 inside");
    run_op(sx32(32'h8000_0000), sx32(32'h8000_0000), 2'b10, 1'b1, "R3 minneg32");
    run_op(zx32(32'hFFFF_FFFF), zx32(32'hFFFF_FFFF), 2'b10, 1'b1, "R3 unsigned ones32");
    run_op(sx32(32'hFFFF_FFFF), sx32(32'h0001_2345), 2'b10, 1'b1, "R3 signed neg32");
  endtask

  task automatic test_random;
    for (int i = 0; i < 30; i++) begin
      logic [63:0] ra, rb;
      logic [1:0]  s;
      logic        m;
      logic        sg;
      logic [64:0] a, b;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      s  = 2'($urandom_range(0, 2));
      m  = 1'($urandom_range(0, 1));
      sg = 1'($urandom_range(0, 1));
      if (m) begin
        a = sg ? sx32(ra[31:0]) : zx32(ra[31:0]);
        b = sg ? sx32(rb[31:0]) : zx32(rb[31:0]);
      end else begin
        a = sg ? sx64(ra) : zx64(ra);
        b = sg ? sx64(rb) : zx64(rb);
      end
      case (s)
        2'b00:   run_op(a, b, s, m, "R1 random low");
        2'b01:   run_op(a, b, s, m, "R2 random high");
        default: run_op(a, b, s, m, "R3 random high32");
      endcase
    end
  endtask

  // R5: second start arrives mid-run with different operands
  task automatic test_busy_start;
    logic [64:0] a1, b1;
    logic [63:0] er;
    logic        eo;
    int          lat;
    int          extra;
    a1 = sx64(64'h0123_4567_89AB_CDEF);
    b1 = sx64(64'hFEDC_BA98_7654_3210);
    expect_ref(a1, b1, 2'b00, 1'b0, er, eo);
    @(negedge clk);
    pulse_start(a1, b1, 2'b00, 1'b0);
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    pulse_start(sx64(64'd3), sx64(64'd5), 2'b01, 1'b0);
    lat++;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 latency unchanged", 64'(lat - 1), 64'd34);
    chk("R5 result of first", result_o, er);
    chk("R5 ovf of first", 64'(ovf_o), 64'(eo));
    extra = 0;
    repeat (45) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk("R5 no extra done", 64'(extra), 64'd0);
  endtask

  // R9: outputs hold while inputs churn and no start is given
  task automatic test_hold;
    logic [63:0] r0;
    logic        o0;
    run_op(sx64(64'h4000_0000_0000_0000), sx64(64'd4), 2'b00, 1'b0, "R6 hold setup");
    r0 = result_o;
    o0 = ovf_o;
    opa_i = sx64(64'd7); opb_i = sx64(64'd9); sel_i = 2'b01;
    repeat (8) @(negedge clk);
    chk("R9 result held", result_o, r0);
    chk("R9 ovf held", 64'(ovf_o), 64'(o0));
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    sel_i = 2'b00;
    mode32_i = 1'b0;
    opa_i = '0;
    opb_i = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_corners();
    test_busy_start();
    test_hold();
    test_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule